// File: doc/BRIEF.md
# Byte-Wide Packet Handshake Engine

This block carries packets one byte at a time between a host and a device. It uses a shared 8-bit data register and three active-low control lines. The host drives two of them: a transfer-in-progress line and an acknowledge line. The device drives the third, a request line. A direction input chooses between two transfers: the host pushing a command packet into the device, or the host pulling a response packet out of it.

Every host write to the control lines is compared with the previous control state. Any change of either host line, while a transfer is in progress, advances the transfer by one byte. In the host-to-device direction the byte in the data register is appended to an outgoing buffer. In the device-to-host direction the next response byte is loaded into the data register. Releasing the in-progress line ends the transfer, and a non-empty outgoing buffer is then reported as a finished packet with its length. While no transfer is in progress, toggling the acknowledge line is mirrored on the request line. This lets the two sides synchronise.

Each byte step, packet end, synchronisation toggle and response load schedules a shift-complete interrupt pulse. The pulse comes after a programmable delay, or on the next cycle when the port-B direction input is all ones.

Top module: `byte_handshake_engine`

## Requirements
- R1: After reset `req_n_o` is 1, `sr_o` is 0x00, and neither `shift_irq_o` nor `pkt_valid_o` pulses until an event occurs.
- R2: Conditions: a control write with `host_tip_n_i`=0, `dir_out_i`=1, and a change of either host line against the previous control write. Result: the current `sr_o` byte is stored at the next outgoing buffer index and an interrupt is scheduled. A control write with no change stores nothing and schedules nothing. `sr_o` is not altered by such writes.
- R3: Once the outgoing buffer holds BUF_DEPTH bytes, further append steps store nothing and schedule no interrupt.
- R4: A control write that raises `host_tip_n_i` from 0 to 1 always schedules an interrupt. If the outgoing buffer is non-empty, it also gives a one-cycle `pkt_valid_o` pulse with `pkt_len_o` equal to the byte count, and resets the count to 0. Otherwise it gives no pulse.
- R5: Conditions: a control write with `host_tip_n_i`=0, `dir_out_i`=0, a change of either host line, and unread response bytes. Result: the next response byte is loaded into `sr_o` and an interrupt is scheduled. With no unread bytes left, `sr_o` is unchanged and no interrupt is scheduled.
- R6: Loading the last response byte drives `req_n_o` to 1.
- R7: A control write with `host_tip_n_i`=1, after a previous write that also had it at 1, and with `host_ack_n_i` changed, copies `host_ack_n_i` onto `req_n_o` and schedules an interrupt.
- R8: A control write with `host_tip_n_i`=1 that is not the R7 case drives `req_n_o` to 0 whenever unread response bytes remain.
- R9: A response load (`resp_load_i`) has three effects. It sets the response length, clamped to BUF_DEPTH. It restarts reading at index 0. It schedules an interrupt. If the last control write left `host_tip_n_i` at 1 and the length is non-zero, it also drives `req_n_o` to 0.
- R10: With `dirb_i` equal to 0xFF, a scheduled interrupt pulses `shift_irq_o` in the cycle after the scheduling edge. Otherwise it pulses DELAY_CYCLES cycles after that edge. A newer scheduling event restarts the delay, so only one pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dir_out_i | input | 1 | 1 = host-to-device, 0 = device-to-host |
| dirb_i | input | 8 | Port-B direction value; 0xFF selects immediate interrupts |
| sr_we_i | input | 1 | Host write strobe for the data register |
| sr_wdata_i | input | 8 | Host data for the data register |
| port_b_we_i | input | 1 | Host write strobe for the control lines |
| host_ack_n_i | input | 1 | Acknowledge line level, active low |
| host_tip_n_i | input | 1 | Transfer-in-progress line level, active low |
| resp_wr_i | input | 1 | Write strobe into the response buffer |
| resp_wr_addr_i | input | $clog2(BUF_DEPTH) | Response buffer write index |
| resp_wr_data_i | input | 8 | Response buffer write data |
| resp_load_i | input | 1 | Commit a response packet; dropped if it coincides with a control write |
| resp_len_i | input | $clog2(BUF_DEPTH+1) | Length of the committed response |
| out_rd_addr_i | input | $clog2(BUF_DEPTH) | Outgoing buffer read index |
| out_rd_data_o | output | 8 | Outgoing buffer byte at the read index |
| sr_o | output | 8 | Data register contents |
| req_n_o | output | 1 | Request line, active low |
| pkt_valid_o | output | 1 | One-cycle pulse: host-to-device packet finished |
| pkt_len_o | output | $clog2(BUF_DEPTH+1) | Byte count of the finished packet |
| shift_irq_o | output | 1 | One-cycle shift-complete interrupt pulse |

## Verification
Two situations are hardest to reach. The first is the synchronisation branch, which needs two consecutive control writes with the in-progress line high and only the acknowledge line moving. The stimulus first ends a transfer, then writes a bare acknowledge toggle, then repeats an identical write to show that nothing changes. The second is the restart of the interrupt delay. With `dirb_i` cleared, the stimulus issues a second event partway through the first delay. It then checks that a single pulse arrives exactly DELAY_CYCLES after the second event. Buffer overflow is reached with a small buffer depth by toggling acknowledge more times than the buffer holds.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    STEP_NONE,
    STEP_APPEND,
    STEP_FETCH,
    STEP_SYNC,
    STEP_RELEASE,
    STEP_POLL
  } step_t;
endpackage

// File: rtl/hs_out_collector.sv
module hs_out_collector #(
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [7:0]    data_i,
  input  logic          clear_i,
  input  logic [IW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [7:0] mem_q [DEPTH];

  assign full_o    = (count_o == CW'(DEPTH));
  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else if (clear_i) count_o <= '0;
    else if (push_i && !full_o) count_o <= count_o + CW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[count_o[IW-1:0]] <= data_i;
  end

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  p_full_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !clear_i) |=> $stable(count_o));
endmodule

// File: rtl/hs_resp_reader.sv
module hs_resp_reader #(
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          adv_i,
  output logic [7:0]    byte_o,
  output logic          remain_o,
  output logic          last_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] len_q, idx_q;

  assign remain_o = idx_q < len_q;
  assign last_o   = (idx_q + CW'(1)) == len_q;
  assign byte_o   = mem_q[idx_q[IW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      len_q <= (len_i > CW'(DEPTH)) ? CW'(DEPTH) : len_i;
      idx_q <= '0;
    end else if (adv_i && remain_o) begin
      idx_q <= idx_q + CW'(1);
    end
  end

  p_idx_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= len_q);
  p_load_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (idx_q == '0));
endmodule

// File: rtl/hs_irq_delay.sv
module hs_irq_delay #(
  parameter int DELAY = 30000,
  parameter int CNTW  = $clog2(DELAY + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic immediate_i,
  output logic irq_o
);
  logic [CNTW-1:0] cnt_q;
  logic            active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (start_i) begin
        if (immediate_i || DELAY == 0) begin
          irq_o    <= 1'b1;
          active_q <= 1'b0;
        end else begin
          cnt_q    <= CNTW'(DELAY);
          active_q <= 1'b1;
        end
      end else if (active_q) begin
        if (cnt_q == CNTW'(1)) begin
          irq_o    <= 1'b1;
          active_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CNTW'(1);
        end
      end
    end
  end

  p_immediate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && immediate_i) |=> irq_o);
  p_quiet_wait_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q > CNTW'(1) && !start_i) |=> !irq_o);
endmodule

// File: rtl/byte_handshake_engine.sv
module byte_handshake_engine
  import hs_pkg::*;
#(
  parameter int BUF_DEPTH    = 16,
  parameter int DELAY_CYCLES = 30000,
  localparam int IW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_out_i,
  input  logic [7:0]    dirb_i,
  input  logic          sr_we_i,
  input  logic [7:0]    sr_wdata_i,
  input  logic          port_b_we_i,
  input  logic          host_ack_n_i,
  input  logic          host_tip_n_i,
  input  logic          resp_wr_i,
  input  logic [IW-1:0] resp_wr_addr_i,
  input  logic [7:0]    resp_wr_data_i,
  input  logic          resp_load_i,
  input  logic [CW-1:0] resp_len_i,
  input  logic [IW-1:0] out_rd_addr_i,
  output logic [7:0]    out_rd_data_o,
  output logic [7:0]    sr_o,
  output logic          req_n_o,
  output logic          pkt_valid_o,
  output logic [CW-1:0] pkt_len_o,
  output logic          shift_irq_o
);
  logic          last_ack_n, last_tip_n;
  logic          b_changed, load_go, schedule;
  logic          out_full, rsp_remain, rsp_last;
  logic [CW-1:0] out_count;
  logic [7:0]    rsp_byte;
  step_t         step;

  assign b_changed = (host_ack_n_i != last_ack_n) || (host_tip_n_i != last_tip_n);
  assign load_go   = resp_load_i && !port_b_we_i;

  always_comb begin
    step = STEP_NONE;
    if (port_b_we_i) begin
      if (!host_tip_n_i) begin
        if (b_changed) begin
          if (dir_out_i) begin
            if (!out_full) step = STEP_APPEND;
          end else if (rsp_remain) begin
            step = STEP_FETCH;
          end
        end
      end else if (last_tip_n && (host_ack_n_i != last_ack_n)) begin
        step = STEP_SYNC;
      end else if (!last_tip_n) begin
        step = STEP_RELEASE;
      end else begin
        step = STEP_POLL;
      end
    end
  end

  assign schedule = (step == STEP_APPEND) || (step == STEP_FETCH) ||
                    (step == STEP_SYNC) || (step == STEP_RELEASE) || load_go;

  hs_out_collector #(.DEPTH(BUF_DEPTH), .IW(IW), .CW(CW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (step == STEP_APPEND),
    .data_i    (sr_o),
    .clear_i   (step == STEP_RELEASE),
    .rd_addr_i (out_rd_addr_i),
    .rd_data_o (out_rd_data_o),
    .count_o   (out_count),
    .full_o    (out_full)
  );

  hs_resp_reader #(.DEPTH(BUF_DEPTH), .IW(IW), .CW(CW)) u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (resp_wr_i),
    .wr_addr_i (resp_wr_addr_i),
    .wr_data_i (resp_wr_data_i),
    .load_i    (load_go),
    .len_i     (resp_len_i),
    .adv_i     (step == STEP_FETCH),
    .byte_o    (rsp_byte),
    .remain_o  (rsp_remain),
    .last_o    (rsp_last)
  );

  hs_irq_delay #(.DELAY(DELAY_CYCLES)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (schedule),
    .immediate_i (dirb_i == 8'hFF),
    .irq_o       (shift_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_ack_n  <= 1'b1;
      last_tip_n  <= 1'b1;
      sr_o        <= '0;
      req_n_o     <= 1'b1;
      pkt_valid_o <= 1'b0;
      pkt_len_o   <= '0;
    end else begin
      pkt_valid_o <= 1'b0;
      if (port_b_we_i) begin
        last_ack_n <= host_ack_n_i;
        last_tip_n <= host_tip_n_i;
      end
      if (step == STEP_FETCH) sr_o <= rsp_byte;
      else if (sr_we_i) sr_o <= sr_wdata_i;
      if (step == STEP_RELEASE && out_count != '0) begin
        pkt_valid_o <= 1'b1;
        pkt_len_o   <= out_count;
      end
      case (step)
        STEP_FETCH:   if (rsp_last) req_n_o <= 1'b1;
        STEP_SYNC:    req_n_o <= host_ack_n_i;
        STEP_RELEASE,
        STEP_POLL:    if (rsp_remain) req_n_o <= 1'b0;
        default:      if (load_go && last_tip_n && resp_len_i != '0) req_n_o <= 1'b0;
      endcase
    end
  end

  p_last_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == STEP_FETCH && rsp_last) |=> req_n_o);
  p_pkt_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (pkt_len_o != '0));
  p_sr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_b_we_i && dir_out_i && !host_tip_n_i && !sr_we_i) |=> $stable(sr_o));
  p_sync_copy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == STEP_SYNC) |=> (req_n_o == $past(host_ack_n_i)));
endmodule

// File: tb/tb_byte_handshake_engine.sv
`timescale 1ns/1ps
module tb_byte_handshake_engine;
  localparam int DEPTH = 4;
  localparam int DLY   = 12;
  localparam int IW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_out = 1'b1;
  logic [7:0] dirb = 8'hFF;
  logic sr_we = 1'b0, b_we = 1'b0, ack_n = 1'b1, tip_n = 1'b1;
  logic [7:0] sr_wd = '0;
  logic rw = 1'b0, rload = 1'b0;
  logic [IW-1:0] rwa = '0, raddr = '0;
  logic [7:0] rwd = '0;
  logic [CW-1:0] rlen = '0;
  logic [7:0] out_rd, sr;
  logic req_n, pkt_v, irq;
  logic [CW-1:0] pkt_len;

  int n_chk = 0, n_fail = 0, cyc = 0, ev_cyc = 0;
  int irq_cnt = 0, irq_cyc = -1, pkt_cnt = 0, pkt_seen_len = 0;
  bit done = 0;

  always #5 clk = ~clk;

  byte_handshake_engine #(.BUF_DEPTH(DEPTH), .DELAY_CYCLES(DLY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_out_i(dir_out), .dirb_i(dirb),
    .sr_we_i(sr_we), .sr_wdata_i(sr_wd), .port_b_we_i(b_we),
    .host_ack_n_i(ack_n), .host_tip_n_i(tip_n), .resp_wr_i(rw),
    .resp_wr_addr_i(rwa), .resp_wr_data_i(rwd), .resp_load_i(rload),
    .resp_len_i(rlen), .out_rd_addr_i(raddr), .out_rd_data_o(out_rd),
    .sr_o(sr), .req_n_o(req_n), .pkt_valid_o(pkt_v), .pkt_len_o(pkt_len),
    .shift_irq_o(irq)
  );

  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (irq) begin irq_cnt++; irq_cyc = cyc; end
    if (pkt_v) begin pkt_cnt++; pkt_seen_len = int'(pkt_len); end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step_clk();
    @(posedge clk); @(negedge clk); ev_cyc = cyc; #1;
  endtask

  task automatic set_sr(input logic [7:0] v);
    sr_we = 1'b1; sr_wd = v; step_clk(); sr_we = 1'b0;
  endtask

  task automatic wb(input logic a, input logic t);
    b_we = 1'b1; ack_n = a; tip_n = t; step_clk(); b_we = 1'b0;
  endtask

  task automatic rsp_put(input int a, input logic [7:0] v);
    rw = 1'b1; rwa = IW'(a); rwd = v; step_clk(); rw = 1'b0;
  endtask

  task automatic rsp_commit(input int len);
    rload = 1'b1; rlen = CW'(len); step_clk(); rload = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk(req_n == 1'b1, "R1 req_n", req_n, 1);
    chk(sr == 8'h00, "R1 sr", sr, 0);
    chk(irq_cnt == 0 && pkt_cnt == 0, "R1 no pulses", irq_cnt + pkt_cnt, 0);
  endtask

  task automatic t_host_to_dev();
    int base;
    dir_out = 1'b1; base = irq_cnt;
    set_sr(8'hA1); wb(1'b1, 1'b0);
    chk(irq_cnt == base + 1, "R2 append irq", irq_cnt, base + 1);
    chk(irq_cyc == ev_cyc, "R10 immediate", irq_cyc - ev_cyc, 0);
    set_sr(8'hB2); wb(1'b0, 1'b0);
    wb(1'b0, 1'b0);
    chk(irq_cnt == base + 2, "R2 no change no irq", irq_cnt, base + 2);
    set_sr(8'hC3); wb(1'b1, 1'b0);
    chk(sr == 8'hC3, "R2 sr untouched", sr, 8'hC3);
    wb(1'b1, 1'b1);
    chk(pkt_cnt == 1 && pkt_seen_len == 3, "R4 pkt len", pkt_seen_len, 3);
    chk(irq_cnt == base + 4, "R4 end irq", irq_cnt, base + 4);
    raddr = 0; #1 chk(out_rd == 8'hA1, "R2 byte0", out_rd, 8'hA1);
    raddr = 1; #1 chk(out_rd == 8'hB2, "R2 byte1", out_rd, 8'hB2);
    raddr = 2; #1 chk(out_rd == 8'hC3, "R2 byte2", out_rd, 8'hC3);
  endtask

  task automatic t_overflow();
    int base;
    base = irq_cnt;
    for (int i = 0; i < 6; i++) begin
      set_sr(8'h10 + 8'(i));
      wb((i % 2) == 0, 1'b0);
      if (i == 3) chk(irq_cnt == base + 4, "R3 four appended", irq_cnt, base + 4);
    end
    chk(irq_cnt == base + 4, "R3 full no irq", irq_cnt, base + 4);
    wb(1'b1, 1'b1);
    chk(pkt_cnt == 2 && pkt_seen_len == DEPTH, "R3 len capped", pkt_seen_len, DEPTH);
    raddr = 3; #1 chk(out_rd == 8'h13, "R3 last kept", out_rd, 8'h13);
  endtask

  task automatic t_empty_end();
    int base;
    dir_out = 1'b0; base = irq_cnt;
    wb(1'b1, 1'b0);
    chk(irq_cnt == base, "R5 no response no irq", irq_cnt, base);
    wb(1'b1, 1'b1);
    chk(pkt_cnt == 2, "R4 empty no pkt", pkt_cnt, 2);
    chk(irq_cnt == base + 1, "R4 empty still irq", irq_cnt, base + 1);
    chk(req_n == 1'b1, "R8 nothing pending", req_n, 1);
  endtask

  task automatic t_dev_to_host();
    int base;
    rsp_put(0, 8'h5A); rsp_put(1, 8'h6B); rsp_put(2, 8'h7C);
    base = irq_cnt;
    rsp_commit(3);
    chk(req_n == 1'b0, "R9 load asserts req", req_n, 0);
    chk(irq_cnt == base + 1, "R9 load irq", irq_cnt, base + 1);
    wb(1'b1, 1'b0);
    chk(sr == 8'h5A && req_n == 1'b0, "R5 first byte", sr, 8'h5A);
    wb(1'b0, 1'b0);
    chk(sr == 8'h6B, "R5 second byte", sr, 8'h6B);
    wb(1'b1, 1'b0);
    chk(sr == 8'h7C, "R5 third byte", sr, 8'h7C);
    chk(req_n == 1'b1, "R6 last releases req", req_n, 1);
    chk(irq_cnt == base + 4, "R5 fetch irqs", irq_cnt, base + 4);
    wb(1'b0, 1'b0);
    chk(sr == 8'h7C && irq_cnt == base + 4, "R5 drained no step", sr, 8'h7C);
    wb(1'b0, 1'b1);
    chk(req_n == 1'b1 && pkt_cnt == 2, "R8 drained release", req_n, 1);
  endtask

  task automatic t_partial_reload();
    rsp_put(0, 8'h11); rsp_put(1, 8'h22);
    rsp_commit(2);
    chk(req_n == 1'b0, "R9 load req", req_n, 0);
    wb(1'b0, 1'b0);
    chk(sr == 8'h11 && req_n == 1'b0, "R5 partial fetch", sr, 8'h11);
    wb(1'b0, 1'b1);
    chk(req_n == 1'b0, "R8 pending after release", req_n, 0);
    rsp_put(0, 8'h33);
    rsp_commit(1);
    wb(1'b0, 1'b0);
    chk(sr == 8'h33, "R9 index restarted", sr, 8'h33);
    chk(req_n == 1'b1, "R6 single byte last", req_n, 1);
    wb(1'b0, 1'b1);
  endtask

  task automatic t_sync();
    int base;
    base = irq_cnt;
    wb(1'b1, 1'b1);
    chk(req_n == 1'b1 && irq_cnt == base + 1, "R7 copy ack high", req_n, 1);
    wb(1'b0, 1'b1);
    chk(req_n == 1'b0 && irq_cnt == base + 2, "R7 copy ack low", req_n, 0);
    wb(1'b0, 1'b1);
    chk(req_n == 1'b0 && irq_cnt == base + 2, "R7 no change", irq_cnt, base + 2);
  endtask

  task automatic t_delay();
    int base;
    dirb = 8'h00; base = irq_cnt;
    wb(1'b1, 1'b1);
    idle(DLY + 8);
    chk(irq_cnt == base + 1, "R10 one delayed pulse", irq_cnt, base + 1);
    chk(irq_cyc - ev_cyc == DLY, "R10 delay length", irq_cyc - ev_cyc, DLY);
    base = irq_cnt;
    wb(1'b0, 1'b1);
    idle(4);
    wb(1'b1, 1'b1);
    idle(DLY + 8);
    chk(irq_cnt == base + 1, "R10 restart single pulse", irq_cnt, base + 1);
    chk(irq_cyc - ev_cyc == DLY, "R10 restart delay", irq_cyc - ev_cyc, DLY);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x1 expected=0x0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_host_to_dev();
    t_overflow();
    t_empty_end();
    t_dev_to_host();
    t_partial_reload();
    t_sync();
    t_delay();
    finish_run();
  end
endmodule